// File: doc/BRIEF.md
# Time-Division Shared Memory Bus Sequencer

This block drives a memory bus that four requesters share by fixed time division. A major bus cycle is split into eight minor slots of equal length. Each slot belongs to one requester and one transfer type, fixed at design time. The block walks through the slots and grants the bus to each owner in turn. It steers that owner's address, write flag and write data onto a single memory port. The owners are an I/O processor, two processors and a DMA channel. Each processor has its own instruction slot and its own data slot. The DMA channel gets two data slots, the I/O processor gets one mixed slot, and one slot is left empty.

A minor slot lasts `SLOT_CLKS` clock cycles. A request is taken only on the first clock of a slot, and only from that slot's owner. If the owner is not requesting, the slot goes unused. No other requester may borrow it. Every requester has a start-of-slot flag, so it knows when to present its request. A side-band output carries the transfer type of the current slot, so the memory side can route its response.

Top module: `tdm_bus_seq`

## Requirements
- R1: `slot_idx` holds for `SLOT_CLKS` clocks, then steps by one. It wraps from 7 to 0. `slot_first` is high on the first clock of each slot and low on the others.
- R2: `major_start` is high only on the first clock of slot 0, including the first clock after reset.
- R3: `grant` is one-hot and marks the owner of the current slot, using bit 0 I/O processor, bit 1 processor A, bit 2 processor B, bit 3 DMA. The owners by slot 0..7 are 0,1,2,3,none,2,1,3.
- R4: `mem_kind` gives the transfer type of the current slot, with 0 none, 1 instruction, 2 data, 3 mixed. The types by slot 0..7 are 3,1,2,2,0,1,2,2.
- R5: `mem_valid` is high only on the first clock of a slot whose owner has `req_valid` high. The `req_valid` bits of non-owners have no effect.
- R6: While `mem_valid` is high, `mem_addr`, `mem_we` and `mem_wdata` equal the owner's inputs. Otherwise all three are zero.
- R7: In slot 4 no grant is given and no memory request is issued, even if every requester is asserting `req_valid`.
- R8: While `rst` is high, `grant`, `owner_first`, `mem_valid`, `major_start` and `mem_kind` are zero in that same cycle. The next clock edge puts the block in the first clock of slot 0.
- R9: `owner_first[i]` equals `grant[i]` on a slot's first clock and is zero on the other clocks.
- R10: The DMA channel holds the grant in exactly two slots per major cycle, slots 3 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; gates outputs at once |
| req_valid | input | NREQ | Per-requester request valid |
| req_we | input | NREQ | Per-requester write flag |
| req_addr | input | NREQ*ADDR_W | Per-requester address, requester i at bits [i*ADDR_W +: ADDR_W] |
| req_wdata | input | NREQ*DATA_W | Per-requester write data, requester i at bits [i*DATA_W +: DATA_W] |
| slot_idx | output | 3 | Current minor slot |
| slot_first | output | 1 | First clock of the current slot |
| major_start | output | 1 | First clock of a major cycle |
| grant | output | NREQ | One-hot owner of the current slot |
| owner_first | output | NREQ | Per-requester start-of-own-slot flag |
| mem_valid | output | 1 | Memory request strobe |
| mem_we | output | 1 | Memory write flag |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_kind | output | 2 | Transfer type of the current slot |

## Verification
All the state in this block is the slot counter and its prescaler. If either holds a wrong value, the error appears on the very next clock edge. It shows as a `slot_idx` step of the wrong size or at the wrong time, or as a grant and `mem_kind` that do not match the slot table. A wrong prescaler phase moves `slot_first`, `owner_first` and `mem_valid` off the clock that is a multiple of `SLOT_CLKS` from reset. The sweep feeds all sixteen request-valid patterns, one per major cycle. This exposes any borrowing or any leak from the idle slot within one major cycle.

// File: rtl/tdm_bus_pkg.sv
package tdm_bus_pkg;

   localparam int NREQ   = 4;
   localparam int SLOTS  = 8;
   localparam int SLOT_W = 3;
   localparam int OWN_W  = 2;

   typedef enum logic [OWN_W-1:0] {
      OWN_IOP  = 2'd0,
      OWN_CPUA = 2'd1,
      OWN_CPUB = 2'd2,
      OWN_DMA  = 2'd3
   } owner_e;

   typedef enum logic [1:0] {
      XF_NONE  = 2'd0,
      XF_INSTR = 2'd1,
      XF_DATA  = 2'd2,
      XF_BOTH  = 2'd3
   } xfer_e;

   typedef struct packed {
      logic   used;
      owner_e owner;
      xfer_e  kind;
   } slot_entry_t;

   // Fixed ownership schedule; the order is the behaviour of the block.
   function automatic slot_entry_t slot_lookup(input logic [SLOT_W-1:0] s);
      slot_entry_t e;
      case (s)
         3'd0:    e = '{used: 1'b1, owner: OWN_IOP,  kind: XF_BOTH};
         3'd1:    e = '{used: 1'b1, owner: OWN_CPUA, kind: XF_INSTR};
         3'd2:    e = '{used: 1'b1, owner: OWN_CPUB, kind: XF_DATA};
         3'd3:    e = '{used: 1'b1, owner: OWN_DMA,  kind: XF_DATA};
         3'd4:    e = '{used: 1'b0, owner: OWN_IOP,  kind: XF_NONE};
         3'd5:    e = '{used: 1'b1, owner: OWN_CPUB, kind: XF_INSTR};
         3'd6:    e = '{used: 1'b1, owner: OWN_CPUA, kind: XF_DATA};
         default: e = '{used: 1'b1, owner: OWN_DMA,  kind: XF_DATA};
      endcase
      return e;
   endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
   import tdm_bus_pkg::*;
#(
   parameter int SLOT_CLKS = 2
) (
   input  logic              clk,
   input  logic              rst,
   output logic [SLOT_W-1:0] slot,
   output logic              first
);

   logic step;

   generate
      if (SLOT_CLKS < 1) begin : g_bad_div
         $error("tdm_slot_timer: SLOT_CLKS must be at least 1");
      end

      if (SLOT_CLKS == 1) begin : g_no_div
         // every clock is a new slot
         assign first = 1'b1;
         assign step  = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(SLOT_CLKS);
         localparam logic [PW-1:0] LAST = PW'(SLOT_CLKS - 1);
         logic [PW-1:0] phase;

         always_ff @(posedge clk) begin
            if (rst) begin
               phase <= '0;
            end else if (phase == LAST) begin
               phase <= '0;
            end else begin
               phase <= phase + PW'(1);
            end
         end

         assign first = (phase == '0);
         assign step  = (phase == LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         slot <= '0;
      end else if (step) begin
         slot <= slot + SLOT_W'(1);
      end
   end

endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table
   import tdm_bus_pkg::*;
(
   input  logic              en,
   input  logic [SLOT_W-1:0] slot,
   output logic [NREQ-1:0]   grant,
   output logic [1:0]        kind
);

   slot_entry_t ent;

   always_comb ent = slot_lookup(slot);

   genvar gi;
   generate
      for (gi = 0; gi < NREQ; gi++) begin : g_gnt
         assign grant[gi] = en && ent.used && (ent.owner == OWN_W'(gi));
      end
   endgenerate

   assign kind = en ? ent.kind : XF_NONE;

endmodule

// File: rtl/tdm_bus_mux.sv
module tdm_bus_mux
   import tdm_bus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic [NREQ-1:0]        sel,
   input  logic [NREQ-1:0]        we_in,
   input  logic [NREQ*ADDR_W-1:0] addr_in,
   input  logic [NREQ*DATA_W-1:0] data_in,
   output logic                   valid,
   output logic                   we,
   output logic [ADDR_W-1:0]      addr,
   output logic [DATA_W-1:0]      data
);

   logic [NREQ-1:0]   we_m;
   logic [ADDR_W-1:0] addr_m [NREQ];
   logic [DATA_W-1:0] data_m [NREQ];

   genvar gi;
   generate
      for (gi = 0; gi < NREQ; gi++) begin : g_lane
         assign we_m[gi]   = sel[gi] & we_in[gi];
         assign addr_m[gi] = sel[gi] ? addr_in[gi*ADDR_W +: ADDR_W] : '0;
         assign data_m[gi] = sel[gi] ? data_in[gi*DATA_W +: DATA_W] : '0;
      end
   endgenerate

   // AND-OR merge: at most one lane is selected
   always_comb begin
      addr = '0;
      data = '0;
      for (int i = 0; i < NREQ; i++) begin
         addr = addr | addr_m[i];
         data = data | data_m[i];
      end
   end

   assign valid = |sel;
   assign we    = |we_m;

endmodule

// File: rtl/tdm_bus_seq.sv
module tdm_bus_seq
   import tdm_bus_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int SLOT_CLKS = 2
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [NREQ-1:0]        req_valid,
   input  logic [NREQ-1:0]        req_we,
   input  logic [NREQ*ADDR_W-1:0] req_addr,
   input  logic [NREQ*DATA_W-1:0] req_wdata,
   output logic [SLOT_W-1:0]      slot_idx,
   output logic                   slot_first,
   output logic                   major_start,
   output logic [NREQ-1:0]        grant,
   output logic [NREQ-1:0]        owner_first,
   output logic                   mem_valid,
   output logic                   mem_we,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [DATA_W-1:0]      mem_wdata,
   output logic [1:0]             mem_kind
);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("tdm_bus_seq: ADDR_W must be positive");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("tdm_bus_seq: DATA_W must be positive");
      end
   endgenerate

   logic            live;
   logic [NREQ-1:0] take;

   assign live = ~rst;

   tdm_slot_timer #(.SLOT_CLKS(SLOT_CLKS)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .slot  (slot_idx),
      .first (slot_first)
   );

   tdm_slot_table u_table (
      .en    (live),
      .slot  (slot_idx),
      .grant (grant),
      .kind  (mem_kind)
   );

   assign owner_first = grant & {NREQ{slot_first}};
   assign take        = owner_first & req_valid;
   assign major_start = live && slot_first && (slot_idx == '0);

   tdm_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
      .sel     (take),
      .we_in   (req_we),
      .addr_in (req_addr),
      .data_in (req_wdata),
      .valid   (mem_valid),
      .we      (mem_we),
      .addr    (mem_addr),
      .data    (mem_wdata)
   );

endmodule

// File: rtl/tdm_bus_seq_chk.sv
module tdm_bus_seq_chk
   import tdm_bus_pkg::*;
(
   input logic              clk,
   input logic              rst,
   input logic [NREQ-1:0]   req_valid,
   input logic [SLOT_W-1:0] slot_idx,
   input logic              slot_first,
   input logic              major_start,
   input logic [NREQ-1:0]   grant,
   input logic [NREQ-1:0]   owner_first,
   input logic              mem_valid,
   input logic [1:0]        mem_kind
);

   logic warm;

   always_ff @(posedge clk) begin
      warm <= ~rst;
   end

   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst || !warm)
      (slot_idx == $past(slot_idx)) || (slot_idx == $past(slot_idx) + 3'd1)); // R1
   AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst || !warm)
      !slot_first |-> $stable(slot_idx)); // R1
   AST_MAJOR_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
      major_start |-> (slot_first && slot_idx == 3'd0)); // R2
   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant)); // R3
   AST_NO_BORROW: assert property (@(posedge clk) disable iff (rst)
      mem_valid |-> (slot_first && |(grant & req_valid))); // R5
   AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (rst)
      (slot_idx == 3'd4) |-> (grant == '0 && !mem_valid && mem_kind == 2'd0)); // R7
   AST_FIRST_FLAG: assert property (@(posedge clk) disable iff (rst)
      !slot_first |-> (owner_first == '0)); // R9
   AST_DMA_SLOTS: assert property (@(posedge clk) disable iff (rst)
      grant[3] |-> (slot_idx == 3'd3 || slot_idx == 3'd7)); // R10

   always @(posedge clk) begin
      if (rst) begin
         AST_RESET_QUIET: assert (grant == '0 && !mem_valid && !major_start && owner_first == '0); // R8
      end
   end

endmodule

bind tdm_bus_seq tdm_bus_seq_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .req_valid   (req_valid),
   .slot_idx    (slot_idx),
   .slot_first  (slot_first),
   .major_start (major_start),
   .grant       (grant),
   .owner_first (owner_first),
   .mem_valid   (mem_valid),
   .mem_kind    (mem_kind)
);

// File: tb/tdm_bus_seq_test.sv
`timescale 1ns/1ps
module tdm_bus_seq_test;

   localparam int AW = 16;
   localparam int DW = 32;
   localparam int D  = 3;
   localparam int NR = 4;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [NR-1:0]  req_valid = '0;
   logic [NR-1:0]  req_we = '0;
   logic [NR*AW-1:0] req_addr = '0;
   logic [NR*DW-1:0] req_wdata = '0;
   logic [2:0]     slot_idx;
   logic           slot_first, major_start, mem_valid, mem_we;
   logic [NR-1:0]  grant, owner_first;
   logic [AW-1:0]  mem_addr;
   logic [DW-1:0]  mem_wdata;
   logic [1:0]     mem_kind;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   tdm_bus_seq #(.ADDR_W(AW), .DATA_W(DW), .SLOT_CLKS(D)) uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .slot_idx(slot_idx),
      .slot_first(slot_first), .major_start(major_start), .grant(grant),
      .owner_first(owner_first), .mem_valid(mem_valid), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_kind(mem_kind)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // slot owner table of R3: -1 means none
   function automatic int owner_of(input int s);
      case (s)
         0: return 0;  1: return 1;  2: return 2;  3: return 3;
         4: return -1; 5: return 2;  6: return 1;  default: return 3;
      endcase
   endfunction

   // transfer type table of R4
   function automatic int kind_of(input int s);
      case (s)
         0: return 3;  1: return 1;  4: return 0;  5: return 1;
         default: return 2;
      endcase
   endfunction

   task automatic drive(input int n, input int pat);
      for (int i = 0; i < NR; i++) begin
         req_valid[i] = pat[i];
         req_we[i]    = ((n >> i) & 1) != 0;
         req_addr[i*AW +: AW]  = AW'((i << 12) + (n & 12'hfff));
         req_wdata[i*DW +: DW] = DW'(32'hA000_0000 + (i << 20) + n);
      end
   endtask

   task automatic check_cycle(input int n, input int pat);
      int s, own, k;
      bit fst, exp_v;
      logic [NR-1:0] eg;
      s   = (n / D) % 8;
      fst = (n % D) == 0;
      own = owner_of(s);
      k   = kind_of(s);
      eg  = (own < 0) ? '0 : NR'(1 << own);
      exp_v = fst && own >= 0 && pat[own];
      chk(slot_idx == 3'(s) && slot_first == fst, "R1 slot/first", {slot_idx, slot_first}, {3'(s), fst});
      chk(major_start == (fst && s == 0), "R2 major_start", major_start, fst && s == 0);
      chk(grant == eg, "R3 grant", grant, eg);
      chk(mem_kind == 2'(k), "R4 kind", mem_kind, k);
      chk(mem_valid == exp_v, "R5 mem_valid", mem_valid, exp_v);
      chk(owner_first == (fst ? eg : '0), "R9 owner_first", owner_first, fst ? eg : '0);
      if (s == 4) chk(!mem_valid && grant == '0, "R7 idle slot", {grant, mem_valid}, 0);
      if (own == 3) chk(s == 3 || s == 7, "R10 dma slot", s, 3);
      if (exp_v) begin
         chk(mem_addr == AW'((own << 12) + (n & 12'hfff)), "R6 addr", mem_addr, (own << 12) + (n & 12'hfff));
         chk(mem_wdata == DW'(32'hA000_0000 + (own << 20) + n), "R6 wdata", mem_wdata, 32'hA000_0000 + (own << 20) + n);
         chk(mem_we == (((n >> own) & 1) != 0), "R6 we", mem_we, (n >> own) & 1);
      end else begin
         chk(mem_addr == '0 && mem_wdata == '0 && !mem_we, "R6 zero when idle", mem_addr, 0);
      end
   endtask

   initial begin
      int dma_count;
      repeat (3) @(negedge clk);
      // R8: outputs quiet during reset
      drive(0, 15);
      #1;
      chk(grant == '0 && owner_first == '0, "R8 grant in reset", grant, 0);
      chk(!mem_valid && !major_start && mem_kind == 2'd0, "R8 mem quiet in reset", {mem_valid, major_start, mem_kind}, 0);
      chk(slot_idx == 3'd0, "R8 slot after reset", slot_idx, 0);
      @(negedge clk);
      rst = 1'b0;
      // sweep: all 16 valid patterns, one per major cycle
      dma_count = 0;
      for (int n = 0; n < 16 * 8 * D; n++) begin
         int pat;
         pat = n / (8 * D);
         drive(n, pat);
         #1;
         check_cycle(n, pat);
         if (grant[3] && slot_first && n < 8 * D) dma_count++;
         @(negedge clk);
      end
      chk(dma_count == 2, "R10 dma slots per major", dma_count, 2);
      // mid-run reset: R8 same-cycle drop, then restart at slot 0
      for (int n = 0; n < 4 * D + 1; n++) @(negedge clk);
      drive(0, 15);
      rst = 1'b1;
      #1;
      chk(grant == '0 && !mem_valid && mem_kind == 2'd0, "R8 mid-run drop", {grant, mem_valid}, 0);
      @(negedge clk);
      chk(slot_idx == 3'd0 && slot_first, "R8 counter cleared", slot_idx, 0);
      rst = 1'b0;
      for (int n = 0; n < 8 * D; n++) begin
         drive(n, 15);
         #1;
         check_cycle(n, 15);
         @(negedge clk);
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule